// File: doc/BRIEF.md
# SPI Serial Memory Page-Erase Controller

This block is the slave-side command engine of an SPI serial memory, limited to the page-erase path. It samples chip select, SCK and SI in mode 0 on the system clock, decodes three instructions (set write enable, erase page, read status), and captures the 16-bit address that follows an erase opcode. An erase is started only when chip select rises right after the last address bit, the write-enable latch is set, no erase is running, and the addressed page is outside the block-protected region. Any other case drops the sequence without a response.

An accepted erase runs for a fixed number of system clocks. While it runs, bit 0 of the status byte reads 1. When it ends, every byte of the chosen page is set to FFh in the internal byte-array model. The array has its own combinational read port. A status read sends the status byte out on SO, and SO is driven only during that read.

Top module: `spi_page_erase`

## Requirements
- R1: After reset, so_oe is 0, the status byte reads {4'b0, bp, 2'b00}, and array byte i holds the low 8 bits of i.
- R2: Opcode 06h with chip select rising after exactly 8 bits sets the write-enable latch (status bit 1). The same opcode ended at any other bit count has no effect.
- R3: Opcode 42h followed by a 16-bit address (MSB first, 24 bits in total) erases one page when accepted, leaving every byte of that page at FFh and all other bytes unchanged. The page is address bits [PAGE_W+PAGE_CNT_W-1:PAGE_W], and all lower and higher address bits are ignored.
- R4: An erase sequence ended by chip select after any bit count other than 24 (for example 23 or 25) changes no byte and leaves the write-enable latch unchanged.
- R5: An erase sequence sent while the write-enable latch is clear changes no byte.
- R6: From an accepted erase until ERASE_CYC clocks later, status bit 0 reads 1, and then it reads 0. Acceptance clears the write-enable latch.
- R7: Block protect bp encodes 0 = none, 1 = upper quarter of pages, 2 = upper half, 3 = all. An erase aimed at a protected page changes no byte, never sets status bit 0, and clears the write-enable latch.
- R8: While status bit 0 is 1, write-enable and erase instructions are ignored.
- R9: Opcode 05h returns the status byte {4'b0, bp[1], bp[0], wel, wip} on SO, MSB first, updated after falling SCK edges. so_oe is high only during that output phase and is low throughout write-enable and erase sequences.
- R10: rd_data shows the array byte at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, restores the array pattern |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI clock, mode 0 |
| si | input | 1 | Serial data in |
| bp | input | 2 | Block-protect setting |
| so | output | 1 | Serial data out, high-impedance when not driven |
| so_oe | output | 1 | High while SO is driven |
| rd_addr | input | PAGE_W+PAGE_CNT_W | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
The erase path is tried with a series of sequences that differ in one respect from a valid erase: no write enable, too few bits, too many bits, a write enable sent during a busy period, and a valid erase whose address carries nonzero bits above and below the page field. These patterns separate the bit-count gate, the latch gate and the busy gate, and they show whether the page is decoded correctly. A sweep then covers every protect setting crossed with every page. After each setting the whole array is compared with a model computed in the bench, which exposes a wrong region boundary or a fill landing on the wrong page. Status reads taken during and after each erase check the timing of the busy bit and the clearing of the latch.

// File: rtl/spi_page_erase.sv
module spi_page_erase #(
  parameter int PAGE_W     = 4,
  parameter int PAGE_CNT_W = 4,
  parameter int ERASE_CYC  = 400
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_n,
  input  logic                          sck,
  input  logic                          si,
  input  logic [1:0]                    bp,
  output logic                          so,
  output logic                          so_oe,
  input  logic [PAGE_W+PAGE_CNT_W-1:0]  rd_addr,
  output logic [7:0]                    rd_data
);
  localparam int MEM_AW = PAGE_W + PAGE_CNT_W;
  localparam int MEM_N  = 1 << MEM_AW;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int TW     = $clog2(ERASE_CYC + 1);
  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_ERA  = 8'h42;
  localparam logic [7:0] OP_STAT = 8'h05;

  logic [2:0]            s_cs, s_sck;
  logic [1:0]            s_si;
  logic [5:0]            bcnt;
  logic [23:0]           sh;
  logic [7:0]            op;
  logic                  wel, so_q;
  logic [TW-1:0]         tmr;
  logic [PAGE_CNT_W-1:0] pg;
  logic [7:0]            mem [MEM_N];
  logic                  prot;

  wire cs_low   = !s_cs[1];
  wire cs_fall  = s_cs[2] && !s_cs[1];
  wire cs_rise  = !s_cs[2] && s_cs[1];
  wire sck_rise = cs_low && !s_sck[2] && s_sck[1];
  wire sck_fall = cs_low && s_sck[2] && !s_sck[1];
  wire wip      = tmr != '0;
  wire [7:0] stat = {4'b0, bp, wel, wip};
  wire [PAGE_CNT_W-1:0] a_pg = sh[PAGE_W +: PAGE_CNT_W];
  wire era_ok = cs_rise && !wip && wel && op == OP_ERA && bcnt == 6'd24;
  wire start  = era_ok && !prot;

  always_comb
    case (bp)
      2'd0:    prot = 1'b0;
      2'd1:    prot = &a_pg[PAGE_CNT_W-1 -: 2];
      2'd2:    prot = a_pg[PAGE_CNT_W-1];
      default: prot = 1'b1;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s_cs  <= 3'b111;
      s_sck <= '0;
      s_si  <= '0;
      bcnt  <= '0;
      sh    <= '0;
      op    <= '0;
      wel   <= 1'b0;
      so_q  <= 1'b0;
      tmr   <= '0;
      pg    <= '0;
    end else begin
      s_cs  <= {s_cs[1:0], cs_n};
      s_sck <= {s_sck[1:0], sck};
      s_si  <= {s_si[0], si};
      if (cs_fall) begin
        bcnt <= '0;
        op   <= '0;
      end else if (sck_rise) begin
        sh <= {sh[22:0], s_si[1]};
        if (bcnt != 6'd63) bcnt <= bcnt + 6'd1;
        if (bcnt == 6'd7) op <= {sh[6:0], s_si[1]};
      end
      if (sck_fall && op == OP_STAT && bcnt >= 6'd8)
        so_q <= stat[~bcnt[2:0]];
      if (cs_rise && !wip && op == OP_WEN && bcnt == 6'd8)
        wel <= 1'b1;
      if (era_ok)
        wel <= 1'b0;
      if (start) begin
        tmr <= TW'(ERASE_CYC);
        pg  <= a_pg;
      end else if (wip) begin
        tmr <= tmr - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= 8'(i);
    end else if (tmr == TW'(1)) begin
      for (int i = 0; i < PAGE_N; i++) mem[{pg, PAGE_W'(i)}] <= 8'hFF;
    end

  assign so_oe   = cs_low && op == OP_STAT && bcnt >= 6'd8;
  assign so      = so_oe ? so_q : 1'bz;
  assign rd_data = mem[rd_addr];

  a_r6_wip_starts_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise));
  a_r2_wel_sets_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));
  a_r6_wel_clear_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> !wel);
  a_r8_busy_ignores_commands: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wip) |=> $stable(wel));
  a_r3_page_filled: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr == TW'(1)) |=> (mem[{pg, {PAGE_W{1'b0}}}] == 8'hFF && !wip));
  a_r9_so_only_in_status: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !wip || !$rose(wip));
endmodule

// File: tb/spi_page_erase_tb.sv
module spi_page_erase_tb;
  localparam int CLK_NS = 10;
  localparam int HALF   = 6;
  localparam int PW     = 4;
  localparam int PCW    = 4;
  localparam int ECYC   = 400;
  localparam int MN     = 1 << (PW + PCW);

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0;
  logic [1:0] bp = 0;
  logic so, so_oe;
  logic [PW+PCW-1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic [7:0] exp_mem [MN];
  int n_chk = 0, n_err = 0;
  logic oe_bad;

  spi_page_erase #(.PAGE_W(PW), .PAGE_CNT_W(PCW), .ERASE_CYC(ECYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .bp(bp),
    .so(so), .so_oe(so_oe), .rd_addr(rd_addr), .rd_data(rd_data));

  always #(CLK_NS/2) clk = ~clk;

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic send(input logic [31:0] v, input int n);
    cs_n = 0;
    wclk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      si = v[i];
      wclk(HALF);
      if (so_oe) oe_bad = 1;
      sck = 1;
      wclk(HALF);
      sck = 0;
    end
    wclk(HALF);
    cs_n = 1;
    wclk(HALF);
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] opc = 8'h05;
    s = 0;
    cs_n = 0;
    wclk(HALF);
    for (int i = 7; i >= 0; i--) begin
      si = opc[i];
      wclk(HALF);
      sck = 1;
      wclk(HALF);
      sck = 0;
    end
    for (int i = 0; i < 8; i++) begin
      si = 0;
      wclk(HALF);
      s = {s[6:0], so};
      sck = 1;
      wclk(HALF);
      sck = 0;
    end
    wclk(HALF);
    cs_n = 1;
    wclk(HALF);
  endtask

  task automatic stat_is(input string tag, input logic [7:0] expv);
    logic [7:0] s;
    rd_status(s);
    chk(tag, s, expv);
  endtask

  task automatic mem_all(input string tag);
    for (int i = 0; i < MN; i++) begin
      rd_addr = (PW+PCW)'(i);
      #1;
      chk(tag, rd_data, exp_mem[i]);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    wclk(3);
    rst_n = 1;
    wclk(3);
    for (int i = 0; i < MN; i++) exp_mem[i] = 8'(i);
  endtask

  function automatic bit prot_of(input int b, input int p);
    case (b)
      0: return 0;
      1: return p >= 12;
      2: return p >= 8;
      default: return 1;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 so_oe idle", so_oe, 0);
    stat_is("R1 status after reset", 8'h00);
    mem_all("R1 reset pattern R10");

    send(32'h420035, 24);
    wclk(ECYC + 20);
    mem_all("R5 erase without write enable");
    stat_is("R5 status", 8'h00);

    send(32'h0C, 9);
    stat_is("R2 write enable with 9 bits", 8'h00);
    send(32'h06, 8);
    stat_is("R2 write enable", 8'h02);

    send(32'h420035 >> 1, 23);
    wclk(ECYC + 20);
    mem_all("R4 erase cut at 23 bits");
    stat_is("R4 latch kept after 23", 8'h02);
    send(32'h420035 << 1, 25);
    wclk(ECYC + 20);
    mem_all("R4 erase at 25 bits");
    stat_is("R4 latch kept after 25", 8'h02);

    oe_bad = 0;
    send(32'h42A535, 24);
    chk("R9 so_oe low during erase sequence", oe_bad, 0);
    stat_is("R6 busy during erase", 8'h01);
    oe_bad = 0;
    send(32'h06, 8);
    chk("R9 so_oe low during write enable", oe_bad, 0);
    wclk(ECYC + 20);
    stat_is("R8 write enable ignored while busy, R6 done", 8'h00);
    for (int i = 0; i < 16; i++) exp_mem[16*3 + i] = 8'hFF;
    mem_all("R3 page 3 filled with FF");

    for (int b = 0; b < 4; b++) begin
      bp = 2'(b);
      do_reset();
      for (int p = 0; p < 16; p++) begin
        logic [15:0] a;
        a = {8'(p*37 + b), 4'(p), 4'(p*5 + 3)};
        send(32'h06, 8);
        send({8'h42, a}, 24);
        if (!prot_of(b, p)) begin
          stat_is("R6 busy in sweep", {4'b0, 2'(b), 2'b01});
          for (int i = 0; i < 16; i++) exp_mem[16*p + i] = 8'hFF;
        end else begin
          stat_is("R7 protected page never busy", {4'b0, 2'(b), 2'b00});
        end
        wclk(ECYC + 20);
        stat_is("R7 R9 status after attempt", {4'b0, 2'(b), 2'b00});
      end
      mem_all("R7 array after protect sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule